// File: doc/BRIEF.md
# SDR SDRAM Command Sequencer

This block sits between a simple single-word request port and one SDR SDRAM device with 4 banks, 12-bit rows, 8-bit columns and a 32-bit data bus that carries a byte mask. After reset it brings the device up on its own. It closes every bank, runs two refresh cycles and programs the mode word. It then accepts one request at a time. Each access opens the row, issues a single-beat READ or WRITE that closes the row again automatically, and waits until the bank may be opened once more.

All spacings between SDRAM commands are counted in clock cycles. The values are parameters and default to a 7.5 ns memory clock. Refresh is kept up by an interval counter. When a refresh is due, it takes priority over the next request as soon as the current access has finished. Read data is captured at the programmed CAS latency and returned with a one-cycle strobe.

The request address is laid out as `{bank[1:0], row[11:0], col[7:0]}`. The SDRAM command pins are `{cs_n, ras_n, cas_n, we_n}`.

Top module: `sdr_cmd_ctrl`

## Requirements
- R1: After reset the pins show, in order: PRECHARGE (0010) with addr[10]=1, AUTO REFRESH (0001) T_RP cycles later, a second AUTO REFRESH T_RFC cycles after the first, and LOAD MODE (0000) T_RFC cycles after the second. req_ready first rises T_MRD-1 cycles after LOAD MODE, so that no command can follow LOAD MODE in fewer than T_MRD cycles.
- R2: The LOAD MODE word on addr selects burst length 1 (bits 2:0 = 000), sequential order (bit 3 = 0) and CAS latency CL (bits 6:4). Bit 9 is 0 and all other bits are 0. The bank lines are 0.
- R3: An accepted request issues ACTIVATE (0011) with its bank and row in the cycle after the accepting edge. READ (0101) or WRITE (0100) follows exactly T_RCD cycles later on the same bank, with addr[10]=1 (auto-precharge) and the column in addr[7:0].
- R4: During the WRITE cycle, dq_oe is 1, dq_out holds the request data and dqm equals the inverted byte enables (dqm bit k masks data bits 8k+7:8k). dq_oe is 0 in every other cycle. dqm is 0 during READ.
- R5: rd_data holds the value present on dq_in at the CL-th rising edge after the edge that samples READ. rd_valid is high for exactly the one cycle that follows that edge.
- R6: No ACTIVATE or AUTO REFRESH reaches a bank before it has closed and precharged. The auto-precharge starts at the later of ACTIVATE+T_RAS and the column command plus T_WR for writes (plus 0 for reads), and it lasts T_RP. Two ACTIVATEs are at least T_RC apart.
- R7: A refresh becomes pending every REF_INTERVAL cycles. While it is pending req_ready is low. In idle, AUTO REFRESH is issued one cycle after it becomes pending, so idle refreshes are exactly REF_INTERVAL apart, and refreshes keep happening while requests stream in.
- R8: ACTIVATE comes at least T_RFC cycles after AUTO REFRESH and at least T_MRD cycles after LOAD MODE.
- R9: In reset the pins show deselect (1111), and req_ready, dq_oe and rd_valid are 0. Outside reset only the encodings above or NOP (0111) appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the SDRAM |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | {bank, row, column} |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Write byte enables, bit k for byte k |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 32 | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Row / column / mode address |
| sd_dq_out | output | 32 | Data driven to the memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 32 | Data returned by the memory |
| sd_dqm | output | 4 | Byte mask, active high |

## Verification
A wrong state or a short gap count shows up on the command pins within the same access. A column command one cycle early or late, or an ACTIVATE reaching a bank still in precharge, is flagged by the cycle-counting memory model at that very command. An off-by-one in the CAS capture pipeline returns the filler word instead of the stored data, and the mismatch appears on rd_data about four cycles after READ. A refresh counter that is off shows up as an idle refresh spacing that differs from REF_INTERVAL, seen one interval after the counter starts.

// File: rtl/sdr_ctrl_pkg.sv
package sdr_ctrl_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_ACT   = 4'b0011,
    CMD_WR    = 4'b0100,
    CMD_RD    = 4'b0101,
    CMD_BST   = 4'b0110,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_INIT_PRE,
    ST_INIT_REF_A,
    ST_INIT_REF_B,
    ST_INIT_LMR,
    ST_IDLE,
    ST_ACCESS
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/sdr_refresh_tick.sv
module sdr_refresh_tick #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pending
);
  localparam int W = $clog2(INTERVAL + 1);
  localparam logic [W-1:0] LAST = W'(INTERVAL - 1);

  logic [W-1:0] cnt;
  logic         wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/sdr_rd_align.sv
module sdr_rd_align #(
  parameter int CL     = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [CL-1:0] tok;

  generate
    if (CL == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) tok <= '0;
        else     tok <= issue;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) tok <= '0;
        else     tok <= {tok[CL-2:0], issue};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= tok[CL-1];
      if (tok[CL-1]) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/sdr_cmd_ctrl.sv
module sdr_cmd_ctrl
  import sdr_ctrl_pkg::*;
#(
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 32,
  parameter int CL           = 3,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_RAS        = 6,
  parameter int T_RC         = 9,
  parameter int T_RFC        = 9,
  parameter int T_WR         = 2,
  parameter int T_MRD        = 2,
  parameter int REF_INTERVAL = 1560
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  input  logic [DATA_W/8-1:0]           req_be,
  output logic                          rd_valid,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [ROW_W-1:0]              sd_addr,
  output logic [DATA_W-1:0]             sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DATA_W-1:0]             sd_dq_in,
  output logic [DATA_W/8-1:0]           sd_dqm
);
  localparam int ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int BE_W   = DATA_W / 8;
  localparam int AP_BIT = 10;
  // Gap after the column command: row cycle, auto-precharge after tRAS, write recovery.
  localparam int T_POST = imax(imax(T_RC - T_RCD, T_RAS - T_RCD + T_RP), T_WR + T_RP);
  localparam int MAX_GAP = imax(imax(imax(T_POST, T_RFC), imax(T_RP, T_RCD)), T_MRD);
  localparam int CNT_W  = $clog2(MAX_GAP + 1);
  localparam logic [ROW_W-1:0] AP_MASK   = ROW_W'(1) << AP_BIT;
  localparam logic [2:0]       BL_ONE    = 3'b000;
  localparam logic [ROW_W-1:0] MODE_WORD = (ROW_W'(CL) << 4) | ROW_W'(BL_ONE);

  seq_state_e             state;
  sdr_cmd_e               cmd_q;
  logic [BANK_W-1:0]      ba_q;
  logic [ROW_W-1:0]       addr_q;
  logic [DATA_W-1:0]      dq_out_q;
  logic                   dq_oe_q;
  logic [BE_W-1:0]        dqm_q;
  logic                   rd_issue_q;

  logic                   h_wr;
  logic [BANK_W-1:0]      h_ba;
  logic [COL_W-1:0]       h_col;
  logic [DATA_W-1:0]      h_data;
  logic [BE_W-1:0]        h_be;

  logic                   busy;
  logic                   tmr_load;
  logic [CNT_W-1:0]       tmr_val;
  logic                   ref_pending;
  logic                   ref_ack;

  logic [BANK_W-1:0]      req_bank;
  logic [ROW_W-1:0]       req_row;
  logic [COL_W-1:0]       req_col;

  assign req_bank = req_addr[ADDR_W-1 -: BANK_W];
  assign req_row  = req_addr[COL_W +: ROW_W];
  assign req_col  = req_addr[COL_W-1:0];

  sdr_gap_timer #(.W(CNT_W)) u_gap (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .busy(busy)
  );

  sdr_refresh_tick #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst(rst), .ack(ref_ack), .pending(ref_pending)
  );

  sdr_rd_align #(.CL(CL), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .issue(rd_issue_q), .dq_in(sd_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // Decide whether a command goes out at this edge and how long to hold off after it.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_ack  = 1'b0;
    if (!busy) begin
      unique case (state)
        ST_INIT_PRE:   begin tmr_load = 1'b1; tmr_val = CNT_W'(T_RP - 1);  end
        ST_INIT_REF_A,
        ST_INIT_REF_B: begin tmr_load = 1'b1; tmr_val = CNT_W'(T_RFC - 1); end
        ST_INIT_LMR:   begin tmr_load = 1'b1; tmr_val = CNT_W'(T_MRD - 1); end
        ST_IDLE: begin
          if (ref_pending) begin
            tmr_load = 1'b1; tmr_val = CNT_W'(T_RFC - 1); ref_ack = 1'b1;
          end else if (req_valid) begin
            tmr_load = 1'b1; tmr_val = CNT_W'(T_RCD - 1);
          end
        end
        ST_ACCESS:     begin tmr_load = 1'b1; tmr_val = CNT_W'(T_POST - 1); end
        default: ;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE) && !busy && !ref_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_INIT_PRE;
      cmd_q      <= CMD_DESEL;
      ba_q       <= '0;
      addr_q     <= '0;
      dq_out_q   <= '0;
      dq_oe_q    <= 1'b0;
      dqm_q      <= '0;
      rd_issue_q <= 1'b0;
      h_wr       <= 1'b0;
      h_ba       <= '0;
      h_col      <= '0;
      h_data     <= '0;
      h_be       <= '0;
    end else begin
      cmd_q      <= CMD_NOP;
      dq_oe_q    <= 1'b0;
      dqm_q      <= '0;
      rd_issue_q <= 1'b0;
      if (tmr_load) begin
        unique case (state)
          ST_INIT_PRE: begin
            cmd_q  <= CMD_PRE;
            addr_q <= AP_MASK;
            ba_q   <= '0;
            state  <= ST_INIT_REF_A;
          end
          ST_INIT_REF_A: begin
            cmd_q <= CMD_REF;
            state <= ST_INIT_REF_B;
          end
          ST_INIT_REF_B: begin
            cmd_q <= CMD_REF;
            state <= ST_INIT_LMR;
          end
          ST_INIT_LMR: begin
            cmd_q  <= CMD_LMR;
            addr_q <= MODE_WORD;
            ba_q   <= '0;
            state  <= ST_IDLE;
          end
          ST_IDLE: begin
            if (ref_pending) begin
              cmd_q <= CMD_REF;
            end else begin
              cmd_q  <= CMD_ACT;
              ba_q   <= req_bank;
              addr_q <= req_row;
              h_wr   <= req_write;
              h_ba   <= req_bank;
              h_col  <= req_col;
              h_data <= req_wdata;
              h_be   <= req_be;
              state  <= ST_ACCESS;
            end
          end
          ST_ACCESS: begin
            cmd_q  <= h_wr ? CMD_WR : CMD_RD;
            ba_q   <= h_ba;
            addr_q <= AP_MASK | ROW_W'(h_col);
            if (h_wr) begin
              dq_oe_q  <= 1'b1;
              dq_out_q <= h_data;
              dqm_q    <= ~h_be;
            end else begin
              rd_issue_q <= 1'b1;
            end
            state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_addr   = addr_q;
  assign sd_dq_out = dq_out_q;
  assign sd_dq_oe  = dq_oe_q;
  assign sd_dqm    = dqm_q;

endmodule

// File: rtl/sdr_cmd_ctrl_chk.sv
module sdr_cmd_ctrl_chk #(
  parameter int T_RCD = 3,
  parameter int T_RC  = 9,
  parameter int T_RFC = 9
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] cmd,
  input logic       dq_oe,
  input logic       req_ready,
  input logic       rd_valid,
  input logic       ref_pending
);
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [7:0] SAT   = 8'hFF;

  logic [7:0] since_act;
  logic [7:0] since_ref;
  logic       act_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_act <= '0;
      since_ref <= '0;
      act_seen  <= 1'b0;
    end else begin
      if (cmd == C_ACT)         begin since_act <= 8'd1; act_seen <= 1'b1; end
      else if (since_act != SAT) since_act <= since_act + 1'b1;
      if (cmd == C_REF)          since_ref <= 8'd1;
      else if (since_ref != SAT) since_ref <= since_ref + 1'b1;
    end
  end

  // R4
  oe_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (cmd == C_WR));

  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R9
  ready_nop_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (cmd == C_NOP));

  // R7
  pending_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    ref_pending |-> !req_ready);

  // R3
  cas_after_act_chk: assert property (@(posedge clk) disable iff (rst)
    ((cmd == C_RD) || (cmd == C_WR)) |-> (since_act == 8'(T_RCD)));

  // R6
  row_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    ((cmd == C_ACT) && act_seen) |-> (since_act >= 8'(T_RC)));

  // R8
  refresh_to_act_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_ACT) |-> (since_ref >= 8'(T_RFC)));

endmodule

bind sdr_cmd_ctrl sdr_cmd_ctrl_chk #(
  .T_RCD(T_RCD), .T_RC(T_RC), .T_RFC(T_RFC)
) chk_i (
  .clk(clk),
  .rst(rst),
  .cmd({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .dq_oe(sd_dq_oe),
  .req_ready(req_ready),
  .rd_valid(rd_valid),
  .ref_pending(ref_pending)
);

// File: tb/sdr_cmd_ctrl_tb_top.sv
module sdr_cmd_ctrl_tb_top;
  localparam int CL = 3, T_RCD = 3, T_RP = 3, T_RAS = 6, T_RC = 9, T_RFC = 9;
  localparam int T_WR = 2, T_MRD = 2, T_RRD = 2, REF_IV = 1560;
  localparam logic [3:0] C_LMR = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010, C_ACT = 4'b0011;
  localparam logic [3:0] C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111, C_DES = 4'b1111;
  localparam logic [31:0] FILL = 32'hBAD0_BAD0;
  localparam int NV = 11;
  // {write, bank, row, col, data (write) or expected data (read), byte enables}
  localparam logic [58:0] VEC [NV] = '{
    {1'b1, 2'd0, 12'd1, 8'd2, 32'hA5A5_0001, 4'hF},
    {1'b0, 2'd0, 12'd1, 8'd2, 32'hA5A5_0001, 4'hF},
    {1'b1, 2'd0, 12'd1, 8'd2, 32'h1122_3344, 4'h5},
    {1'b0, 2'd0, 12'd1, 8'd2, 32'hA522_0044, 4'hF},
    {1'b1, 2'd3, 12'd5, 8'd7, 32'hDEAD_BEEF, 4'h8},
    {1'b0, 2'd3, 12'd5, 8'd7, 32'hDE00_0000, 4'hF},
    {1'b1, 2'd2, 12'd2, 8'd1, 32'hCAFE_F00D, 4'h3},
    {1'b1, 2'd1, 12'd7, 8'd3, 32'h1234_5678, 4'hF},
    {1'b0, 2'd2, 12'd2, 8'd1, 32'h0000_F00D, 4'hF},
    {1'b0, 2'd1, 12'd7, 8'd3, 32'h1234_5678, 4'hF},
    {1'b0, 2'd0, 12'd0, 8'd0, 32'h0000_0000, 4'hF}
  };

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_ready, req_write;
  logic [21:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_be;
  logic rd_valid;
  logic [31:0] rd_data;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;
  logic [31:0] sd_dq_out, sd_dq_in;
  logic sd_dq_oe;
  logic [3:0]  sd_dqm;

  always #5 clk = ~clk;

  sdr_cmd_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in), .sd_dqm(sd_dqm)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int act_cyc [4], ready_cyc [4];
  bit open_b [4];
  logic [11:0] open_row [4];
  int last_ref = -1000, last_lmr = -1000, last_act = -1000;
  int log_n = 0;
  logic [3:0] log_cmd [4];
  logic [11:0] log_addr [4];
  logic [1:0] log_ba [4];
  int log_cyc [4];
  int ref_count = 0, rw_seen = 0, rd_seen = 0;
  int rd_due = -1, rd_cmd_cyc = -1, first_ready = -1;
  logic [31:0] rd_val;
  logic [31:0] mem [256];
  bit idle_mode = 0;
  int last_idle_ref = -1;
  logic [1:0] exp_ba;
  logic [11:0] exp_row;
  logic [7:0] exp_col;
  logic [31:0] exp_wdata, exp_rdata;
  logic [3:0] exp_be;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Cycle-counting memory responder, looks at the pins mid-cycle.
  initial begin
    logic [3:0] c;
    logic [7:0] idx;
    bit ok;
    sd_dq_in = FILL;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int b = 0; b < 4; b++) begin
      act_cyc[b] = -1000; ready_cyc[b] = 0; open_b[b] = 0; open_row[b] = '0;
    end
    forever begin
      @(negedge clk);
      if (rst) begin cyc = 0; continue; end
      cyc++;
      sd_dq_in = (cyc == rd_due) ? rd_val : FILL;
      if (req_ready && first_ready < 0) first_ready = cyc;
      if (rd_valid) begin
        chk(cyc == rd_cmd_cyc + CL + 1, "R5 rd_valid cycle", cyc, rd_cmd_cyc + CL + 1);
        chk(rd_data == exp_rdata, "R5 rd_data", rd_data, exp_rdata);
        rd_seen++;
      end
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (sd_dq_oe && c != C_WR) chk(0, "R4 dq_oe outside write", sd_dq_oe, 0);
      if (log_n < 4 && c != C_NOP && c != C_DES) begin
        log_cmd[log_n] = c; log_addr[log_n] = sd_addr; log_ba[log_n] = sd_ba;
        log_cyc[log_n] = cyc; log_n++;
      end
      case (c)
        C_PRE: for (int b = 0; b < 4; b++)
          if (sd_addr[10] || sd_ba == 2'(b)) begin open_b[b] = 0; ready_cyc[b] = cyc + T_RP; end
        C_REF, C_LMR: begin
          ok = 1;
          for (int b = 0; b < 4; b++) if (open_b[b] || cyc < ready_cyc[b]) ok = 0;
          chk(ok, "R6 banks idle before refresh/mode", ok, 1);
          chk(cyc - last_ref >= T_RFC, "R8 refresh spacing", cyc - last_ref, T_RFC);
          chk(cyc - last_lmr >= T_MRD, "R8 mode spacing", cyc - last_lmr, T_MRD);
          if (c == C_REF) begin
            if (idle_mode && last_idle_ref >= 0)
              chk(cyc - last_idle_ref == REF_IV, "R7 idle refresh period", cyc - last_idle_ref, REF_IV);
            if (idle_mode) last_idle_ref = cyc;
            last_ref = cyc; ref_count++;
          end else last_lmr = cyc;
        end
        C_ACT: begin
          chk(!open_b[sd_ba] && cyc >= ready_cyc[sd_ba], "R6 bank ready", cyc, ready_cyc[sd_ba]);
          chk(cyc - act_cyc[sd_ba] >= T_RC, "R6 row cycle", cyc - act_cyc[sd_ba], T_RC);
          chk(cyc - last_act >= T_RRD, "R6 act-act", cyc - last_act, T_RRD);
          chk(cyc - last_ref >= T_RFC, "R8 refresh to act", cyc - last_ref, T_RFC);
          chk(cyc - last_lmr >= T_MRD, "R8 mode to act", cyc - last_lmr, T_MRD);
          chk({sd_ba, sd_addr} == {exp_ba, exp_row}, "R3 act target", {sd_ba, sd_addr}, {exp_ba, exp_row});
          open_b[sd_ba] = 1; open_row[sd_ba] = sd_addr; act_cyc[sd_ba] = cyc; last_act = cyc;
        end
        C_RD, C_WR: begin
          chk(open_b[sd_ba] && cyc - act_cyc[sd_ba] == T_RCD, "R3 act to column gap",
              cyc - act_cyc[sd_ba], T_RCD);
          chk(sd_addr[10] && sd_addr[7:0] == exp_col && sd_ba == exp_ba, "R3 column address",
              {sd_ba, sd_addr}, {exp_ba, 4'b0100, exp_col});
          idx = {sd_ba, open_row[sd_ba][2:0], sd_addr[2:0]};
          if (c == C_WR) begin
            chk(sd_dq_oe && sd_dq_out == exp_wdata && sd_dqm == ~exp_be, "R4 write beat",
                {sd_dq_oe, sd_dqm, sd_dq_out}, {1'b1, ~exp_be, exp_wdata});
            for (int k = 0; k < 4; k++) if (!sd_dqm[k]) mem[idx][8*k +: 8] = sd_dq_out[8*k +: 8];
            ready_cyc[sd_ba] = imax(act_cyc[sd_ba] + T_RAS, cyc + T_WR) + T_RP;
          end else begin
            chk(sd_dqm == 4'h0, "R4 read mask", sd_dqm, 0);
            rd_due = cyc + CL; rd_val = mem[idx]; rd_cmd_cyc = cyc;
            ready_cyc[sd_ba] = imax(act_cyc[sd_ba] + T_RAS, cyc) + T_RP;
          end
          open_b[sd_ba] = 0; rw_seen++;
        end
        C_NOP, C_DES: ;
        default: chk(0, "R9 unexpected command", c, C_NOP);
      endcase
    end
  end

  task automatic do_req(input logic [58:0] v);
    int rw0, rd0, guard;
    exp_ba = v[57:56]; exp_row = v[55:44]; exp_col = v[43:36];
    exp_wdata = v[35:4]; exp_rdata = v[35:4]; exp_be = v[58] ? v[3:0] : 4'hF;
    rw0 = rw_seen; rd0 = rd_seen;
    req_write = v[58]; req_addr = {v[57:56], v[55:44], v[43:36]};
    req_wdata = v[35:4]; req_be = v[3:0]; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while ((rw_seen == rw0 || (!v[58] && rd_seen == rd0)) && guard < 100) begin
      @(negedge clk); guard++;
    end
    chk(guard < 100, v[58] ? "R3 write completes" : "R5 read returns", guard, 0);
  endtask

  initial begin
    int r0;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R9 ready in reset", req_ready, 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_DES, "R9 deselect in reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_DES);
    chk(sd_dq_oe == 1'b0 && rd_valid == 1'b0, "R9 oe/rd_valid in reset", {sd_dq_oe, rd_valid}, 0);
    rst = 1'b0;
    while (first_ready < 0) @(negedge clk);
    chk(log_cmd[0] == C_PRE && log_addr[0][10], "R1 precharge all first", log_cmd[0], C_PRE);
    chk(log_cmd[1] == C_REF && log_cyc[1] - log_cyc[0] == T_RP, "R1 first refresh",
        log_cyc[1] - log_cyc[0], T_RP);
    chk(log_cmd[2] == C_REF && log_cyc[2] - log_cyc[1] == T_RFC, "R1 second refresh",
        log_cyc[2] - log_cyc[1], T_RFC);
    chk(log_cmd[3] == C_LMR && log_cyc[3] - log_cyc[2] == T_RFC, "R1 load mode",
        log_cyc[3] - log_cyc[2], T_RFC);
    chk(first_ready - log_cyc[3] == T_MRD - 1, "R1 ready after mode", first_ready - log_cyc[3], T_MRD - 1);
    chk(log_addr[3] == 12'(CL << 4) && log_ba[3] == 2'd0, "R2 mode word", log_addr[3], CL << 4);

    for (int i = 0; i < NV; i++) do_req(VEC[i]);

    idle_mode = 1; last_idle_ref = -1; r0 = ref_count;
    repeat (2 * REF_IV + 100) @(negedge clk);
    idle_mode = 0;
    chk(ref_count - r0 >= 2 && ref_count - r0 <= 3, "R7 idle refresh count", ref_count - r0, 2);

    r0 = ref_count;
    for (int i = 0; i < 220; i++) do_req(VEC[3]);
    chk(ref_count - r0 >= 1, "R7 refresh between accesses", ref_count - r0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule